// File: doc/BRIEF.md
# Dual-Lane Address Generator with Per-Pointer Modifiers

This block produces memory operand addresses for a signal-processing datapath. It keeps four register triplets. Each triplet holds a pointer, a step (offset) and a modifier, and all three share one index. A request names a pointer and an addressing mode. The block returns the effective address and the pointer value after update. The modifier of the named triplet decides how the pointer moves: plain 16-bit wraparound, wrap inside a circular buffer, or bit-reversed carry for FFT-style access.

Two request lanes work in the same cycle, each with its own register triplet. Lane A may name any of the four pointers. Lane B is limited to the upper pair. A single configuration port loads and reads every pointer, step and modifier. When a configuration write and the lanes target the same pointer in one cycle, a fixed priority decides which value is kept.

Top module: `dsp_agu`

## Requirements
- R1: After a synchronous active-high reset, every pointer and step register is 0x0000 and every modifier is 0xFFFF. `a_done`, `b_done` and `cfg_rdata` are 0.
- R2: `cfg_kind` selects the register class: 0 pointer, 1 step, 2 modifier. Kind 3 is ignored on write and reads as 0. When `cfg_we` is high, `cfg_wdata` goes into the register chosen by `cfg_kind` and `cfg_idx`. On every clock edge, `cfg_rdata` captures the value that register held before any write in the same cycle.
- R3: The mode code takes these values. 0: the address is the pointer and the pointer is unchanged. 1: the address is the pointer, then the pointer steps by +1. 2: the address is the pointer, then the pointer steps by -1. 3: the address is the pointer, then the pointer steps by the step register. 4: the address is pointer plus step, with no update. 5: the address is pointer plus the sign-extended 6-bit displacement, with no update. Codes 6 and 7 behave like 0.
- R4: The address, the new pointer value and the done flag are registered. They appear on the clock edge that samples the request. The new pointer output equals the old pointer for modes that do not update.
- R5: A modifier of 0xFFFF, or any value from 0x8000 to 0xFFFE, selects plain modulo-2^16 arithmetic.
- R6: A modifier m from 0x0001 to 0x7FFF selects a circular buffer of size m+1. The buffer base is the pointer with its low bit-length(m) bits cleared. offset + step is corrected once: add the size if the result is negative, or subtract the size if the result is at least the size.
- R7: A modifier of 0x0000 selects reverse-carry addition. The result is the bit reverse of (bit reverse of pointer + bit reverse of step).
- R8: The addresses of modes 4 and 5 are formed with the same modifier arithmetic as the pointer updates.
- R9: Lane A indexes pointer 0–3 with a 2-bit field. Lane B's 1-bit index selects pointer 2 (0) or pointer 3 (1). Each lane uses the step and modifier of its own pointer.
- R10: When both lanes update the same pointer in one cycle, lane A's result is stored.
- R11: A configuration write to a pointer overrides any lane update of that pointer in the same cycle.
- R12: Both lanes complete independent requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_kind | input | 2 | Register class: 0 pointer, 1 step, 2 modifier |
| cfg_idx | input | 2 | Triplet index for read and write |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Registered read data |
| a_req | input | 1 | Lane A request |
| a_idx | input | 2 | Lane A pointer index |
| a_mode | input | 3 | Lane A mode code |
| a_disp | input | 6 | Lane A signed displacement |
| a_ea | output | 16 | Lane A effective address |
| a_ptr | output | 16 | Lane A pointer after update |
| a_done | output | 1 | Lane A result valid |
| b_req | input | 1 | Lane B request |
| b_idx | input | 1 | Lane B pointer select (2 or 3) |
| b_mode | input | 3 | Lane B mode code |
| b_disp | input | 6 | Lane B signed displacement |
| b_ea | output | 16 | Lane B effective address |
| b_ptr | output | 16 | Lane B pointer after update |
| b_done | output | 1 | Lane B result valid |

## Verification
In a single cycle, pointer write-back can meet a configuration write to the same pointer, or lane A and lane B can both update one pointer. Directed cycles set up each of these collisions. The random phase also lets both occur, since lane A often names pointer 2 or 3 while lane B is active and a pointer write is pending. The result is judged by reading the pointer back through the configuration port. It is also judged by the pointer value the next request returns, both compared against a bench model that applies write over lane A over lane B.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    K_PTR  = 2'd0,
    K_STEP = 2'd1,
    K_MOD  = 2'd2,
    K_NONE = 2'd3
  } reg_kind_e;

  typedef enum logic [2:0] {
    MD_PLAIN = 3'd0,
    MD_INC   = 3'd1,
    MD_DEC   = 3'd2,
    MD_POSTN = 3'd3,
    MD_IDX   = 3'd4,
    MD_DISP  = 3'd5
  } lane_mode_e;

endpackage

// File: rtl/agu_arith.sv
module agu_arith #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] modif,
  output logic [DW-1:0] result
);

  logic [DW-1:0]        mask;
  logic [DW-1:0]        lin_res;
  logic [DW-1:0]        rev_a;
  logic [DW-1:0]        rev_b;
  logic [DW-1:0]        rev_sum;
  logic [DW-1:0]        rev_res;
  logic [DW-1:0]        mod_res;
  logic signed [DW+1:0] off;
  logic signed [DW+1:0] size;

  // Bit-length mask of the modifier: ones from its top set bit downwards
  always_comb begin
    mask = modif;
    for (int i = DW - 2; i >= 0; i--) mask[i] = mask[i] | mask[i+1];
  end

  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : g_rev
      assign rev_a[g]   = base_val[DW-1-g];
      assign rev_b[g]   = step[DW-1-g];
      assign rev_res[g] = rev_sum[DW-1-g];
    end
  endgenerate

  assign rev_sum = rev_a + rev_b;
  assign lin_res = base_val + step;

  always_comb begin
    size = $signed({2'b00, modif}) + $signed({{(DW+1){1'b0}}, 1'b1});
    off  = $signed({2'b00, base_val & mask}) + $signed({{2{step[DW-1]}}, step});
    if (off < 0)          off = off + size;
    else if (off >= size) off = off - size;
    mod_res = (base_val & ~mask) | (off[DW-1:0] & mask);
  end

  always_comb begin
    if (modif == '0)         result = rev_res;
    else if (!modif[DW-1])   result = mod_res;
    else                     result = lin_res;
  end

endmodule

// File: rtl/agu_lane.sv
module agu_lane
  import agu_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DISP_W = 6
) (
  input  logic [DW-1:0]     ptr,
  input  logic [DW-1:0]     ofs,
  input  logic [DW-1:0]     modif,
  input  logic [2:0]        mode,
  input  logic [DISP_W-1:0] disp,
  output logic [DW-1:0]     ea,
  output logic [DW-1:0]     ptr_next,
  output logic              writeback
);

  localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] M_ONE = '1;

  logic [DW-1:0] step;
  logic [DW-1:0] sum;

  always_comb begin
    step      = '0;
    writeback = 1'b0;
    unique case (mode)
      MD_INC:   begin step = ONE;   writeback = 1'b1; end
      MD_DEC:   begin step = M_ONE; writeback = 1'b1; end
      MD_POSTN: begin step = ofs;   writeback = 1'b1; end
      MD_IDX:   step = ofs;
      MD_DISP:  step = {{(DW-DISP_W){disp[DISP_W-1]}}, disp};
      default:  step = '0;
    endcase
  end

  agu_arith #(.DW(DW)) u_arith (
    .base_val (ptr),
    .step     (step),
    .modif    (modif),
    .result   (sum)
  );

  assign ea       = (mode == MD_IDX || mode == MD_DISP) ? sum : ptr;
  assign ptr_next = writeback ? sum : ptr;

endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NREG  = 4,
  parameter int NLANE = 2,
  localparam int IW   = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [1:0]                 kind,
  input  logic [IW-1:0]              idx,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  input  logic [NLANE-1:0]           upd_en,
  input  logic [NLANE-1:0][IW-1:0]   upd_idx,
  input  logic [NLANE-1:0][DW-1:0]   upd_data,
  output logic [NREG-1:0][DW-1:0]    ptr_q,
  output logic [NREG-1:0][DW-1:0]    ofs_q,
  output logic [NREG-1:0][DW-1:0]    mod_q
);

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic             wr_here;
      logic [DW-1:0]    lane_val;
      logic             lane_hit;

      assign wr_here = we && (idx == IW'(g));

      // Lower lane number has priority
      always_comb begin
        lane_hit = 1'b0;
        lane_val = ptr_q[g];
        for (int l = NLANE - 1; l >= 0; l--) begin
          if (upd_en[l] && upd_idx[l] == IW'(g)) begin
            lane_hit = 1'b1;
            lane_val = upd_data[l];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          ptr_q[g] <= '0;
          ofs_q[g] <= '0;
          mod_q[g] <= '1;
        end else begin
          if (wr_here && kind == K_PTR) ptr_q[g] <= wdata;
          else if (lane_hit)            ptr_q[g] <= lane_val;
          if (wr_here && kind == K_STEP) ofs_q[g] <= wdata;
          if (wr_here && kind == K_MOD)  mod_q[g] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (kind)
        K_PTR:   rdata <= ptr_q[idx];
        K_STEP:  rdata <= ofs_q[idx];
        K_MOD:   rdata <= mod_q[idx];
        default: rdata <= '0;
      endcase
    end
  end

  // R11
  cfg_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (we && kind == K_PTR) |=> ptr_q[$past(idx)] == $past(wdata));

  // R10
  lane0_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en[0] && upd_en[NLANE-1] && upd_idx[0] == upd_idx[NLANE-1] &&
     !(we && kind == K_PTR && idx == upd_idx[0]))
    |=> ptr_q[$past(upd_idx[0])] == $past(upd_data[0]));

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NREG   = 4,
  parameter int DISP_W = 6,
  localparam int IW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              a_req,
  input  logic [IW-1:0]     a_idx,
  input  logic [2:0]        a_mode,
  input  logic [DISP_W-1:0] a_disp,
  output logic [DW-1:0]     a_ea,
  output logic [DW-1:0]     a_ptr,
  output logic              a_done,
  input  logic              b_req,
  input  logic [IW-2:0]     b_idx,
  input  logic [2:0]        b_mode,
  input  logic [DISP_W-1:0] b_disp,
  output logic [DW-1:0]     b_ea,
  output logic [DW-1:0]     b_ptr,
  output logic              b_done
);

  localparam int NLANE = 2;

  logic [NREG-1:0][DW-1:0]      ptr_q, ofs_q, mod_q;
  logic [NLANE-1:0]             l_req;
  logic [NLANE-1:0][IW-1:0]     l_idx;
  logic [NLANE-1:0][2:0]        l_mode;
  logic [NLANE-1:0][DISP_W-1:0] l_disp;
  logic [NLANE-1:0][DW-1:0]     l_ea, l_next;
  logic [NLANE-1:0]             l_wb, l_upd;
  logic [NLANE-1:0][DW-1:0]     ea_q, ptr_o;
  logic [NLANE-1:0]             done_q;

  assign l_req  = {b_req, a_req};
  assign l_idx  = {{1'b1, b_idx}, a_idx};
  assign l_mode = {b_mode, a_mode};
  assign l_disp = {b_disp, a_disp};

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      agu_lane #(.DW(DW), .DISP_W(DISP_W)) u_lane (
        .ptr       (ptr_q[l_idx[g]]),
        .ofs       (ofs_q[l_idx[g]]),
        .modif     (mod_q[l_idx[g]]),
        .mode      (l_mode[g]),
        .disp      (l_disp[g]),
        .ea        (l_ea[g]),
        .ptr_next  (l_next[g]),
        .writeback (l_wb[g])
      );

      assign l_upd[g] = l_req[g] && l_wb[g];

      always_ff @(posedge clk) begin
        if (rst) begin
          ea_q[g]   <= '0;
          ptr_o[g]  <= '0;
          done_q[g] <= 1'b0;
        end else begin
          done_q[g] <= l_req[g];
          if (l_req[g]) begin
            ea_q[g]  <= l_ea[g];
            ptr_o[g] <= l_next[g];
          end
        end
      end
    end
  endgenerate

  agu_regfile #(.DW(DW), .NREG(NREG), .NLANE(NLANE)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .kind     (cfg_kind),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .upd_en   (l_upd),
    .upd_idx  (l_idx),
    .upd_data (l_next),
    .ptr_q    (ptr_q),
    .ofs_q    (ofs_q),
    .mod_q    (mod_q)
  );

  assign a_ea   = ea_q[0];
  assign a_ptr  = ptr_o[0];
  assign a_done = done_q[0];
  assign b_ea   = ea_q[1];
  assign b_ptr  = ptr_o[1];
  assign b_done = done_q[1];

  // R4
  req_done_chk: assert property (@(posedge clk) disable iff (rst)
    a_req |=> a_done);

  // R3
  plain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (a_req && a_mode == MD_PLAIN) |=> (a_ptr == a_ea));

  // R4
  b_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (b_req && (b_mode == MD_IDX || b_mode == MD_DISP)) |=> (b_ptr == $past(ptr_q[{1'b1, b_idx}])));

endmodule

// File: tb/dsp_agu_test.sv
`timescale 1ns/1ps
module dsp_agu_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_kind;
  logic [1:0]  cfg_idx;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        a_req, b_req;
  logic [1:0]  a_idx;
  logic [0:0]  b_idx;
  logic [2:0]  a_mode, b_mode;
  logic [5:0]  a_disp, b_disp;
  logic [15:0] a_ea, a_ptr, b_ea, b_ptr;
  logic        a_done, b_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] mP [4];
  logic [15:0] mS [4];
  logic [15:0] mM [4];

  always #2.5 clk = ~clk;

  dsp_agu uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .a_req(a_req), .a_idx(a_idx), .a_mode(a_mode), .a_disp(a_disp),
    .a_ea(a_ea), .a_ptr(a_ptr), .a_done(a_done),
    .b_req(b_req), .b_idx(b_idx), .b_mode(b_mode), .b_disp(b_disp),
    .b_ea(b_ea), .b_ptr(b_ptr), .b_done(b_done)
  );

  function automatic logic [15:0] brev(input logic [15:0] v);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) o[i] = v[15-i];
    return o;
  endfunction

  function automatic logic [15:0] calc(input logic [15:0] p, input logic [15:0] s,
                                       input logic [15:0] m);
    logic [15:0] mask;
    int off, sz;
    if (m == 16'h0000) return brev(brev(p) + brev(s));
    if (m[15]) return p + s;
    mask = m;
    for (int i = 14; i >= 0; i--) mask[i] = mask[i] | mask[i+1];
    off = int'(p & mask) + int'($signed(s));
    sz  = int'(m) + 1;
    if (off < 0) off += sz;
    else if (off >= sz) off -= sz;
    return (p & ~mask) | (16'(off) & mask);
  endfunction

  function automatic logic [15:0] step_of(input logic [2:0] md, input logic [15:0] s,
                                          input logic [5:0] d);
    case (md)
      3'd1: return 16'h0001;
      3'd2: return 16'hFFFF;
      3'd3, 3'd4: return s;
      3'd5: return {{10{d[5]}}, d};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit upd_mode(input logic [2:0] md);
    return md == 3'd1 || md == 3'd2 || md == 3'd3;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_kind = 2'd0; cfg_idx = 0; cfg_wdata = 0;
    a_req = 0; a_idx = 0; a_mode = 0; a_disp = 0;
    b_req = 0; b_idx = 0; b_mode = 0; b_disp = 0;
  endtask

  // One clock: predict, advance, compare, update model
  task automatic run(input string tag);
    int ai, bi;
    logic [15:0] e_rd, e_aea, e_aptr, e_bea, e_bptr, sa, sb, ra, rb;
    bit e_ad, e_bd, wa, wb;
    ai = int'(a_idx);
    bi = 2 + int'(b_idx);
    case (cfg_kind)
      2'd0: e_rd = mP[cfg_idx];
      2'd1: e_rd = mS[cfg_idx];
      2'd2: e_rd = mM[cfg_idx];
      default: e_rd = 16'h0000;
    endcase
    sa = step_of(a_mode, mS[ai], a_disp);
    sb = step_of(b_mode, mS[bi], b_disp);
    ra = calc(mP[ai], sa, mM[ai]);
    rb = calc(mP[bi], sb, mM[bi]);
    wa = upd_mode(a_mode);
    wb = upd_mode(b_mode);
    e_aea  = (a_mode == 3'd4 || a_mode == 3'd5) ? ra : mP[ai];
    e_aptr = wa ? ra : mP[ai];
    e_bea  = (b_mode == 3'd4 || b_mode == 3'd5) ? rb : mP[bi];
    e_bptr = wb ? rb : mP[bi];
    e_ad = a_req; e_bd = b_req;
    @(posedge clk);
    @(negedge clk);
    check(tag, "cfg_rdata", cfg_rdata, e_rd);
    check(tag, "a_done", {15'd0, a_done}, {15'd0, e_ad});
    check(tag, "b_done", {15'd0, b_done}, {15'd0, e_bd});
    if (e_ad) begin
      check(tag, "a_ea", a_ea, e_aea);
      check(tag, "a_ptr", a_ptr, e_aptr);
    end
    if (e_bd) begin
      check(tag, "b_ea", b_ea, e_bea);
      check(tag, "b_ptr", b_ptr, e_bptr);
    end
    // priority: configuration write, then lane A, then lane B
    if (b_req && wb) mP[bi] = rb;
    if (a_req && wa) mP[ai] = ra;
    if (cfg_we) begin
      case (cfg_kind)
        2'd0: mP[cfg_idx] = cfg_wdata;
        2'd1: mS[cfg_idx] = cfg_wdata;
        2'd2: mM[cfg_idx] = cfg_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [1:0] i, input logic [15:0] d,
                    input string tag);
    cfg_we = 1; cfg_kind = k; cfg_idx = i; cfg_wdata = d;
    run(tag);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] k, input logic [1:0] i, input string tag);
    cfg_kind = k; cfg_idx = i;
    run(tag);
  endtask

  task automatic lane_a(input logic [1:0] i, input logic [2:0] md, input logic [5:0] d,
                        input string tag);
    a_req = 1; a_idx = i; a_mode = md; a_disp = d;
    run(tag);
    a_req = 0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    idle();
    rst = 1;
    for (int i = 0; i < 4; i++) begin mP[i] = 0; mS[i] = 0; mM[i] = 16'hFFFF; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "cfg_rdata", cfg_rdata, 16'h0000);
    check("R1", "a_done", {15'd0, a_done}, 16'h0000);
    check("R1", "b_done", {15'd0, b_done}, 16'h0000);
    rst = 0;
    // R1 reset contents
    rd(2'd2, 2'd0, "R1");
    rd(2'd2, 2'd3, "R1");
    rd(2'd0, 2'd1, "R1");
    rd(2'd1, 2'd2, "R1");

    // R2 writes, read-before-write, kind 3 ignored
    wr(2'd0, 2'd0, 16'h1234, "R2");
    wr(2'd0, 2'd0, 16'h2000, "R2");
    wr(2'd3, 2'd0, 16'hDEAD, "R2");
    rd(2'd0, 2'd0, "R2");
    wr(2'd1, 2'd0, 16'h0010, "R2");
    rd(2'd1, 2'd0, "R2");

    // R3 / R5 linear modes on pointer 0
    lane_a(2'd0, 3'd0, 6'd0, "R3");
    lane_a(2'd0, 3'd1, 6'd0, "R3");
    lane_a(2'd0, 3'd2, 6'd0, "R3");
    lane_a(2'd0, 3'd3, 6'd0, "R3");
    lane_a(2'd0, 3'd4, 6'd0, "R3");
    lane_a(2'd0, 3'd5, 6'h3D, "R3");
    lane_a(2'd0, 3'd6, 6'd0, "R3");
    lane_a(2'd0, 3'd7, 6'd0, "R3");
    wr(2'd0, 2'd0, 16'hFFFF, "R5");
    lane_a(2'd0, 3'd1, 6'd0, "R5");
    wr(2'd2, 2'd0, 16'h9000, "R5");
    wr(2'd0, 2'd0, 16'h0000, "R5");
    lane_a(2'd0, 3'd2, 6'd0, "R5");

    // R6 circular buffer of six at base 0x0100
    wr(2'd2, 2'd1, 16'h0005, "R6");
    wr(2'd0, 2'd1, 16'h0105, "R6");
    lane_a(2'd1, 3'd1, 6'd0, "R6");
    lane_a(2'd1, 3'd2, 6'd0, "R6");
    wr(2'd1, 2'd1, 16'h0004, "R6");
    wr(2'd0, 2'd1, 16'h0103, "R6");
    lane_a(2'd1, 3'd3, 6'd0, "R6");
    wr(2'd1, 2'd1, 16'hFFFC, "R6");
    lane_a(2'd1, 3'd3, 6'd0, "R6");

    // R8 indexed and displacement follow the modifier
    lane_a(2'd1, 3'd4, 6'd0, "R8");
    lane_a(2'd1, 3'd5, 6'h3B, "R8");

    // R7 reverse carry
    wr(2'd2, 2'd2, 16'h0000, "R7");
    wr(2'd1, 2'd2, 16'h8000, "R7");
    wr(2'd0, 2'd2, 16'h0000, "R7");
    for (int k = 0; k < 5; k++) lane_a(2'd2, 3'd3, 6'd0, "R7");
    lane_a(2'd2, 3'd2, 6'd0, "R7");

    // R9 lane B reaches pointer 3 with its own step
    wr(2'd1, 2'd3, 16'h0020, "R9");
    wr(2'd0, 2'd3, 16'h4000, "R9");
    b_req = 1; b_idx = 1'b1; b_mode = 3'd3; run("R9");
    b_idx = 1'b0; b_mode = 3'd1; run("R9");
    b_req = 0;

    // R10 both lanes update pointer 2
    wr(2'd2, 2'd2, 16'hFFFF, "R10");
    wr(2'd0, 2'd2, 16'h0500, "R10");
    a_req = 1; a_idx = 2'd2; a_mode = 3'd1;
    b_req = 1; b_idx = 1'b0; b_mode = 3'd2;
    run("R10");
    idle();
    rd(2'd0, 2'd2, "R10");

    // R11 write beats lane update
    a_req = 1; a_idx = 2'd3; a_mode = 3'd1;
    cfg_we = 1; cfg_kind = 2'd0; cfg_idx = 2'd3; cfg_wdata = 16'h7777;
    run("R11");
    idle();
    rd(2'd0, 2'd3, "R11");

    // R12 independent lanes in one cycle
    a_req = 1; a_idx = 2'd0; a_mode = 3'd1;
    b_req = 1; b_idx = 1'b1; b_mode = 3'd2;
    run("R12");
    idle();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] mv;
      case ($urandom % 6)
        0: mv = 16'hFFFF;
        1: mv = 16'h0000;
        2: mv = 16'h0007;
        3: mv = 16'h0005;
        4: mv = 16'h00FF;
        default: mv = 16'($urandom);
      endcase
      cfg_we    = ($urandom % 4) == 0;
      cfg_kind  = 2'($urandom);
      cfg_idx   = 2'($urandom);
      cfg_wdata = (cfg_kind == 2'd2) ? mv :
                  (cfg_kind == 2'd1) ? 16'($signed(6'($urandom))) : 16'($urandom);
      a_req  = ($urandom % 4) != 0;
      a_idx  = 2'($urandom);
      a_mode = 3'($urandom);
      a_disp = 6'($urandom);
      b_req  = ($urandom % 3) != 0;
      b_idx  = 1'($urandom);
      b_mode = 3'($urandom);
      b_disp = 6'($urandom);
      run("R12");
    end
    idle();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule